// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block places a small shared word memory behind several requester ports and provides the load-linked and store-conditional pair. It also handles ordinary reads and writes. Each port can present one request per cycle. A fixed-priority arbiter grants a single request per cycle. A granted load-linked returns the stored word and leaves a reservation for that port on the address. A later store-conditional from the same port to the same address commits only if no write has reached that address in the meantime. The response reports success or failure. Software combines the two operations into atomic read-modify-write sequences such as test-and-set, fetch-and-add or compare-and-swap.

Each port holds one reservation, made of a valid flag and an address. Every committed write clears every reservation that matches its address. A write counts as committed when it is a granted plain write or a successful conditional store. A conditional store can also fail in the cycle it is presented. This happens when the port loses arbitration to a write that commits to the same address in that cycle. Its response is then issued without a grant. A conditional store that fails never writes memory and never disturbs any other port's reservation.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no response is valid, every memory word reads as 0 and no port holds a reservation.
- R2: When several ports request in the same cycle, only the lowest-indexed valid port is granted. At most one grant is high per cycle. A port that is not granted keeps its request and receives no response.
- R3: Each request that is consumed in a cycle gets exactly one response on the next cycle. A request is consumed when it is granted, or when it is a conditional store that fails by conflict. For a read (op code 0) and a load-linked (op code 2), `rsp_rdata` carries the word that memory held when the request was granted.
- R4: A granted plain write (op code 1) updates the word in the cycle it is granted. Its response has `rsp_sc_ok` = 0 and `rsp_rdata` = 0.
- R5: A granted conditional store (op code 3) succeeds only under two conditions. The port must hold a valid reservation, and that reservation must be on the same address. On success it writes memory and responds with `rsp_sc_ok` = 1. On failure it responds with `rsp_sc_ok` = 0.
- R6: Between a port's load-linked and its conditional store, a committed write to that address from another port makes the conditional store fail. The word keeps the other port's value.
- R7: A conditional store presented in the same cycle as a committed write to the same address from a higher-priority port is not granted. It still gets a response on the next cycle, with `rsp_sc_ok` = 0.
- R8: A failed conditional store writes nothing to memory and leaves every other port's reservation in place.
- R9: A conditional store always clears its own port's reservation. After a successful one, a second conditional store with no new load-linked fails.
- R10: A new load-linked replaces the port's earlier reservation. A conditional store to the earlier address then fails.
- R11: A committed write to a different address leaves a reservation intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_PORTS | Request present, one bit per port |
| req_op | input | NUM_PORTS*2 | Operation per port: 0 read, 1 write, 2 load-linked, 3 conditional store |
| req_addr | input | NUM_PORTS*ADDR_W | Word address per port |
| req_wdata | input | NUM_PORTS*DATA_W | Store data per port |
| grant | output | NUM_PORTS | Request accepted this cycle (combinational) |
| rsp_valid | output | NUM_PORTS | Response valid, one cycle after the request is consumed |
| rsp_rdata | output | NUM_PORTS*DATA_W | Read data per port |
| rsp_sc_ok | output | NUM_PORTS | Conditional store succeeded (1) or failed (0) |

## Verification
The properties assume that a requester keeps its request valid until it is granted or, for a conditional store, until it gets a response. They also assume that requests never use an op code outside the four defined ones. The bench drives each request at the falling edge and holds it for the cycle in which the request is consumed. It drops the request at the next falling edge, once the response has been sampled, so every request the bench makes meets both assumptions. Contention cases present simultaneous requests on purpose and release each port only after it has been served.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    localparam int OP_W = 2;

    typedef enum logic [OP_W-1:0] {
        OP_READ       = 2'd0,
        OP_WRITE      = 2'd1,
        OP_LOAD_LINK  = 2'd2,
        OP_STORE_COND = 2'd3
    } mem_op_e;

    function automatic logic op_returns_data(input mem_op_e op);
        return (op == OP_READ) || (op == OP_LOAD_LINK);
    endfunction

endpackage

// File: rtl/llsc_arbiter.sv
module llsc_arbiter #(
    parameter int NUM_PORTS = 4,
    localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic [NUM_PORTS-1:0] req,
    output logic [NUM_PORTS-1:0] gnt,
    output logic                 win_any,
    output logic [IDX_W-1:0]     win_idx
);

    always_comb begin
        gnt     = '0;
        win_any = 1'b0;
        win_idx = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (req[i] && !win_any) begin
                win_any = 1'b1;
                win_idx = IDX_W'(i);
                gnt[i]  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/llsc_resv_slot.sv
module llsc_resv_slot #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic              clr_self,
    input  logic              snoop_en,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              hold_valid,
    output logic [ADDR_W-1:0] hold_addr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_valid <= 1'b0;
            hold_addr  <= '0;
        end else if (set_en) begin
            hold_valid <= 1'b1;
            hold_addr  <= set_addr;
        end else if (clr_self || (snoop_en && hold_valid && snoop_addr == hold_addr)) begin
            hold_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/llsc_word_mem.sv
module llsc_word_mem #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) words[i] <= '0;
        end else if (we) begin
            words[waddr] <= wdata;
        end
    end

    assign rdata = words[raddr];

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_PORTS-1:0]        req_valid,
    input  logic [NUM_PORTS*OP_W-1:0]   req_op,
    input  logic [NUM_PORTS*ADDR_W-1:0] req_addr,
    input  logic [NUM_PORTS*DATA_W-1:0] req_wdata,
    output logic [NUM_PORTS-1:0]        grant,
    output logic [NUM_PORTS-1:0]        rsp_valid,
    output logic [NUM_PORTS*DATA_W-1:0] rsp_rdata,
    output logic [NUM_PORTS-1:0]        rsp_sc_ok
);

    localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    mem_op_e           op_a   [NUM_PORTS];
    logic [ADDR_W-1:0] addr_a [NUM_PORTS];
    logic [DATA_W-1:0] data_a [NUM_PORTS];
    logic [ADDR_W-1:0] resv_a [NUM_PORTS];
    logic [NUM_PORTS-1:0] resv_v;
    logic [NUM_PORTS-1:0] done;

    logic              win_any;
    logic [IDX_W-1:0]  win_idx;
    mem_op_e           w_op;
    logic [ADDR_W-1:0] w_addr;
    logic [DATA_W-1:0] w_data;
    logic              sc_pass;
    logic              commit;
    logic [DATA_W-1:0] mem_rdata;

    llsc_arbiter #(.NUM_PORTS(NUM_PORTS)) arb_i (
        .req     (req_valid),
        .gnt     (grant),
        .win_any (win_any),
        .win_idx (win_idx)
    );

    assign w_op    = op_a[win_idx];
    assign w_addr  = addr_a[win_idx];
    assign w_data  = data_a[win_idx];
    assign sc_pass = win_any && (w_op == OP_STORE_COND) &&
                     resv_v[win_idx] && (resv_a[win_idx] == w_addr);
    assign commit  = win_any && ((w_op == OP_WRITE) || sc_pass);

    llsc_word_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) mem_i (
        .clk   (clk),
        .rst   (rst),
        .we    (commit),
        .waddr (w_addr),
        .wdata (w_data),
        .raddr (w_addr),
        .rdata (mem_rdata)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic is_sc;
        logic lost;

        assign op_a[p]   = mem_op_e'(req_op[p*OP_W +: OP_W]);
        assign addr_a[p] = req_addr[p*ADDR_W +: ADDR_W];
        assign data_a[p] = req_wdata[p*DATA_W +: DATA_W];

        assign is_sc   = req_valid[p] && (op_a[p] == OP_STORE_COND);
        // conditional store beaten in the same cycle by a write to its address
        assign lost    = is_sc && !grant[p] && commit && (w_addr == addr_a[p]);
        assign done[p] = grant[p] || lost;

        llsc_resv_slot #(.ADDR_W(ADDR_W)) slot_i (
            .clk        (clk),
            .rst        (rst),
            .set_en     (grant[p] && (op_a[p] == OP_LOAD_LINK)),
            .set_addr   (addr_a[p]),
            .clr_self   (done[p] && is_sc),
            .snoop_en   (commit),
            .snoop_addr (w_addr),
            .hold_valid (resv_v[p]),
            .hold_addr  (resv_a[p])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                rsp_valid[p]                  <= 1'b0;
                rsp_sc_ok[p]                  <= 1'b0;
                rsp_rdata[p*DATA_W +: DATA_W] <= '0;
            end else begin
                rsp_valid[p]                  <= done[p];
                rsp_sc_ok[p]                  <= grant[p] && sc_pass;
                rsp_rdata[p*DATA_W +: DATA_W] <=
                    (grant[p] && op_returns_data(op_a[p])) ? mem_rdata : '0;
            end
        end
    end

endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk
    import llsc_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input logic                      clk,
    input logic                      rst,
    input logic [NUM_PORTS-1:0]      req_valid,
    input logic [NUM_PORTS*OP_W-1:0] req_op,
    input logic [NUM_PORTS-1:0]      grant,
    input logic [NUM_PORTS-1:0]      rsp_valid,
    input logic [NUM_PORTS-1:0]      rsp_sc_ok
);

    assert_single_grant_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    assert_port0_first_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid[0] |-> grant[0]);

    assert_grant_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
        (grant & ~req_valid) == '0);

    assert_someone_served_R2: assert property (@(posedge clk) disable iff (rst)
        (|req_valid) |-> (|grant));

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        assert_rsp_follows_grant_R3: assert property (@(posedge clk) disable iff (rst)
            grant[p] |=> rsp_valid[p]);

        assert_ok_in_rsp_R5: assert property (@(posedge clk) disable iff (rst)
            rsp_sc_ok[p] |-> rsp_valid[p]);

        assert_ok_from_granted_sc_R5: assert property (@(posedge clk) disable iff (rst)
            rsp_sc_ok[p] |-> $past(grant[p] && req_op[p*OP_W +: OP_W] == OP_STORE_COND));

        assert_no_rsp_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
            !req_valid[p] |=> !rsp_valid[p]);
    end

endmodule

bind llsc_monitor llsc_monitor_chk #(.NUM_PORTS(NUM_PORTS)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .grant     (grant),
    .rsp_valid (rsp_valid),
    .rsp_sc_ok (rsp_sc_ok)
);

// File: tb/llsc_monitor_tb.sv
`timescale 1ns/1ps
module llsc_monitor_tb_top;

    localparam int N  = 4;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int NV = 26;
    localparam int WATCHDOG_CYCLES = 20000;

    localparam logic [1:0] RD = 2'd0, WR = 2'd1, LL = 2'd2, SC = 2'd3;

    typedef struct packed {
        logic [1:0]    port;
        logic [1:0]    op;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          exp_ok;
        logic [DW-1:0] exp_rdata;
    } vec_t;

    // sequential single-port script; comment names the requirement each row targets
    localparam vec_t VECS [NV] = '{
        '{2'd0, RD, 4'd3,  16'h0000, 1'b0, 16'h0000}, // R1 memory cleared
        '{2'd1, WR, 4'd3,  16'h1111, 1'b0, 16'h0000}, // R4
        '{2'd2, RD, 4'd3,  16'h0000, 1'b0, 16'h1111}, // R3
        '{2'd0, LL, 4'd3,  16'h0000, 1'b0, 16'h1111}, // R5
        '{2'd0, SC, 4'd3,  16'h2222, 1'b1, 16'h0000}, // R5 success
        '{2'd1, RD, 4'd3,  16'h0000, 1'b0, 16'h2222}, // R5 written
        '{2'd0, SC, 4'd3,  16'h3333, 1'b0, 16'h0000}, // R9 reservation used up
        '{2'd1, RD, 4'd3,  16'h0000, 1'b0, 16'h2222}, // R9 no write
        '{2'd2, LL, 4'd5,  16'h0000, 1'b0, 16'h0000}, // R6
        '{2'd3, WR, 4'd5,  16'h0055, 1'b0, 16'h0000}, // R6 intervening write
        '{2'd2, SC, 4'd5,  16'h0AAA, 1'b0, 16'h0000}, // R6 fails
        '{2'd0, RD, 4'd5,  16'h0000, 1'b0, 16'h0055}, // R6 value kept
        '{2'd1, LL, 4'd6,  16'h0000, 1'b0, 16'h0000}, // R10
        '{2'd1, LL, 4'd7,  16'h0000, 1'b0, 16'h0000}, // R10 replaces
        '{2'd1, SC, 4'd6,  16'h0066, 1'b0, 16'h0000}, // R10 old address fails
        '{2'd0, RD, 4'd6,  16'h0000, 1'b0, 16'h0000}, // R10 no write
        '{2'd3, LL, 4'd8,  16'h0000, 1'b0, 16'h0000}, // R11
        '{2'd0, WR, 4'd9,  16'h0099, 1'b0, 16'h0000}, // R11 other address
        '{2'd3, SC, 4'd8,  16'h0088, 1'b1, 16'h0000}, // R11 still succeeds
        '{2'd2, RD, 4'd8,  16'h0000, 1'b0, 16'h0088}, // R11
        '{2'd1, LL, 4'd11, 16'h0000, 1'b0, 16'h0000}, // R8
        '{2'd2, LL, 4'd11, 16'h0000, 1'b0, 16'h0000}, // R8
        '{2'd2, SC, 4'd12, 16'h0D0D, 1'b0, 16'h0000}, // R8 fails, wrong address
        '{2'd0, RD, 4'd12, 16'h0000, 1'b0, 16'h0000}, // R8 nothing written
        '{2'd1, SC, 4'd11, 16'h0C0C, 1'b1, 16'h0000}, // R8 other reservation intact
        '{2'd3, RD, 4'd11, 16'h0000, 1'b0, 16'h0C0C}  // R8
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    req_valid = '0;
    logic [N*2-1:0]  req_op = '0;
    logic [N*AW-1:0] req_addr = '0;
    logic [N*DW-1:0] req_wdata = '0;
    logic [N-1:0]    grant;
    logic [N-1:0]    rsp_valid;
    logic [N*DW-1:0] rsp_rdata;
    logic [N-1:0]    rsp_sc_ok;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    llsc_monitor #(.NUM_PORTS(N), .ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .grant     (grant),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_sc_ok (rsp_sc_ok)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic put(input int p, input logic [1:0] op,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
        req_valid[p]          = 1'b1;
        req_op[p*2 +: 2]      = op;
        req_addr[p*AW +: AW]  = a;
        req_wdata[p*DW +: DW] = d;
    endtask

    task automatic issue(input int p, input logic [1:0] op,
                         input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic exp_ok, input logic [DW-1:0] exp_rd,
                         input string req);
        @(negedge clk);
        put(p, op, a, d);
        #1;
        check(req, "grant", 32'(grant), 32'(1 << p));
        @(negedge clk);
        check(req, "rsp_valid", 32'(rsp_valid), 32'(1 << p));
        check(req, "rsp_sc_ok", 32'(rsp_sc_ok[p]), 32'(exp_ok));
        check(req, "rsp_rdata", 32'(rsp_rdata[p*DW +: DW]), 32'(exp_rd));
        req_valid = '0;
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
        check("R1", "rsp_sc_ok after reset", 32'(rsp_sc_ok), 32'd0);
        check("R1", "grant idle", 32'(grant), 32'd0);

        // R1 no reservation after reset: SC fails at once
        issue(3, SC, 4'd1, 16'h7777, 1'b0, 16'h0000, "R1");
        issue(0, RD, 4'd1, 16'h0000, 1'b0, 16'h0000, "R1");

        for (int v = 0; v < NV; v++) begin
            issue(int'(VECS[v].port), VECS[v].op, VECS[v].addr, VECS[v].wdata,
                  VECS[v].exp_ok, VECS[v].exp_rdata, $sformatf("vec%0d", v));
        end

        // R2 all ports contend; served strictly in index order
        @(negedge clk);
        for (int p = 0; p < N; p++) put(p, RD, 4'd3, 16'h0);
        for (int k = 0; k < N; k++) begin
            #1;
            check("R2", "grant order", 32'(grant), 32'(1 << k));
            @(negedge clk);
            check("R2", "only served port responds", 32'(rsp_valid), 32'(1 << k));
            check("R3", "contended read data", 32'(rsp_rdata[k*DW +: DW]), 32'h2222);
            req_valid[k] = 1'b0;
        end

        // R7 conditional store loses to same-cycle write from a higher priority port
        issue(2, LL, 4'd10, 16'h0, 1'b0, 16'h0000, "R7");
        issue(3, LL, 4'd10, 16'h0, 1'b0, 16'h0000, "R7");
        @(negedge clk);
        put(0, WR, 4'd10, 16'h00A0);
        put(2, SC, 4'd10, 16'h0BBB);
        #1;
        check("R7", "grant to writer only", 32'(grant), 32'h1);
        @(negedge clk);
        check("R7", "both respond", 32'(rsp_valid), 32'h5);
        check("R7", "lost store fails", 32'(rsp_sc_ok), 32'h0);
        req_valid = '0;
        issue(1, RD, 4'd10, 16'h0, 1'b0, 16'h00A0, "R7");
        issue(3, SC, 4'd10, 16'h0CCC, 1'b0, 16'h0000, "R6");
        issue(2, SC, 4'd10, 16'h0DDD, 1'b0, 16'h0000, "R9");
        issue(1, RD, 4'd10, 16'h0, 1'b0, 16'h00A0, "R8");

        // R2/R8 no conflict: different addresses, lower port still waits one cycle
        issue(2, LL, 4'd13, 16'h0, 1'b0, 16'h0000, "R11");
        @(negedge clk);
        put(1, WR, 4'd14, 16'h00E0);
        put(2, SC, 4'd13, 16'h00D0);
        #1;
        check("R2", "higher priority first", 32'(grant), 32'h2);
        @(negedge clk);
        check("R11", "unrelated write, store waits", 32'(rsp_valid), 32'h2);
        req_valid[1] = 1'b0;
        #1;
        check("R11", "store granted next", 32'(grant), 32'h4);
        @(negedge clk);
        check("R11", "store succeeds", 32'(rsp_sc_ok), 32'h4);
        req_valid = '0;
        issue(0, RD, 4'd13, 16'h0, 1'b0, 16'h00D0, "R5");

        finished = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule